// File: doc/BRIEF.md
# Prioritized Interrupt Identifier Encoder

This block turns the interrupt sources of a message-object controller into one 16-bit identifier and one interrupt request line. There is a single status source and a vector of per-object pending flags (32 by default). The identifier names the pending source with the highest priority. The status source outranks every object. Among the objects, the lowest-numbered pending object wins, no matter which flag was set first.

The status source is raised inside the block from event pulses, and each event kind is gated by its own enable. A completed transfer or a detected bus error counts only when the status-change enable is set. A change of the bus-off or warning state counts only when the error enable is set. Once raised, the status source stays pending until a status-register read strobe arrives. The object flags belong to the surrounding logic: the block only observes them, and an object's identifier goes away only when its flag drops.

The identifier is registered. The request line combines the registered identifier with the module enable and has no further delay.

Top module: `intsrc_prio_enc`

## Requirements
- R1: While reset is asserted and right after it, the identifier is 0x0000 and the request line is low.
- R2: When no source is pending, the identifier is 0x0000.
- R3: A pending status source is reported as identifier 0x8000, whatever object flags are set.
- R4: With no status source pending, the identifier is i+1 for the lowest set bit i of the pending vector, so bit 0 gives 1 and bit 31 gives 32.
- R5: The order in which object flags were set is ignored: a lower-numbered flag that sets later replaces a higher-numbered one already reported.
- R6: The request line is high exactly when the identifier is non-zero and the module enable is high; the enable acts in the same cycle.
- R7: A transfer-done or bus-error pulse raises the status source only while the status-change enable is high.
- R8: A bus-state-change pulse raises the status source only while the error enable is high.
- R9: The status source stays pending until a status-read strobe, and a read with no new event clears it.
- R10: A status read in the same cycle as an enabled status event leaves the status source pending.
- R11: The status read strobe has no effect on an object identifier; it persists until its flag is cleared.
- R12: Inputs sampled at a rising clock edge appear on the identifier right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| objPending | input | 32 | Pending flags; bit i belongs to object i+1 |
| xferDone | input | 1 | Pulse: a message transfer completed |
| busErr | input | 1 | Pulse: a bus error was detected |
| busStateChg | input | 1 | Pulse: the bus-off or warning state changed |
| modIntEn | input | 1 | Module interrupt enable |
| statusIntEn | input | 1 | Status-change interrupt enable |
| errIntEn | input | 1 | Error interrupt enable |
| statusRead | input | 1 | Strobe: the status register is being read |
| intId | output | 16 | Identifier of the highest-priority pending source |
| irq | output | 1 | Interrupt request |

## Verification
The only hidden state is the status-pending bit, and the identifier carries it to the ports one edge after any change. If the bit sticks or drops too early, the identifier shows a wrong 0x8000 or a wrong object number in the very next cycle. Many of the stimulus rows keep object flags set while the status source comes and goes. This shows a wrong priority order or a wrong clear as a mismatch between 0x8000 and a small object number, not as a plain zero. Rows that pulse an event with its enable low, and a row that pairs a read with an event, show a wrong gate or a wrong set-versus-clear choice in the same cycle.

// File: rtl/intid_pkg.sv
package intid_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic statusNext;   // status source pending after this edge
    logic statusRaise;  // an enabled status event is present this cycle
  } ctrl_strobe_t;

endpackage

// File: rtl/intid_ctrl.sv
module intid_ctrl
  import intid_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xferDone,
  input  logic         busErr,
  input  logic         busStateChg,
  input  logic         statusIntEn,
  input  logic         errIntEn,
  input  logic         statusRead,
  output ctrl_strobe_t strobe
);

  logic statusPend;
  logic xferRaise;
  logic errRaise;
  logic anyRaise;
  logic pendNext;

  // Each event kind is gated by its own enable
  assign xferRaise = statusIntEn & (xferDone | busErr);
  assign errRaise  = errIntEn & busStateChg;
  assign anyRaise  = xferRaise | errRaise;

  // A new event wins over a read in the same cycle
  assign pendNext = anyRaise | (statusPend & ~statusRead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusPend <= 1'b0;
    else        statusPend <= pendNext;
  end

  always_comb begin
    strobe             = '0;
    strobe.statusNext  = pendNext;
    strobe.statusRaise = anyRaise;
  end

  // R9: the pending status stays set while no read arrives
  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (statusPend && !statusRead) |=> statusPend);

  // R9: a read with no enabled event clears the status
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRead && !(statusIntEn && (xferDone || busErr)) && !(errIntEn && busStateChg))
      |=> !statusPend);

  // R10: an enabled event sets the status even with a read present
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (statusIntEn && xferDone && statusRead) |=> statusPend);

  // R7: with both enables low, an idle status stays idle
  p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!statusIntEn && !errIntEn && !statusPend) |=> !statusPend);

endmodule

// File: rtl/intid_path.sv
module intid_path
  import intid_pkg::*;
#(
  parameter int             NUM_OBJ   = 32,
  parameter int             ID_W      = 16,
  parameter logic [ID_W-1:0] STATUS_ID = 16'h8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_strobe_t       strobe,
  input  logic [NUM_OBJ-1:0] objPending,
  input  logic               modIntEn,
  output logic [ID_W-1:0]    intId,
  output logic               irq
);

  logic [ID_W-1:0] objId;
  logic [ID_W-1:0] idNext;
  logic [ID_W-1:0] intIdQ;

  // Lowest set bit wins: scan downwards so the lowest index overwrites
  always_comb begin
    objId = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (objPending[i]) objId = ID_W'(i + 1);
    end
  end

  // The status source outranks every object
  assign idNext = strobe.statusNext ? STATUS_ID : objId;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intIdQ <= '0;
    else        intIdQ <= idNext;
  end

  assign intId = intIdQ;
  assign irq   = modIntEn & (|intIdQ);

  // R7: an enabled status event shows as the status identifier next cycle
  p_raise_reported_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.statusRaise |=> (intId == STATUS_ID));

  // R2: nothing pending gives a zero identifier after the edge
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.statusNext && (objPending == '0)) |=> (intId == '0));

  // R4: an object identifier stays in the range of object numbers
  p_obj_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((intId != '0) && (intId != STATUS_ID)) |-> (intId <= ID_W'(NUM_OBJ)));

  // R6: the request line never rises without the module enable
  p_irq_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (modIntEn && (intId != '0)));

endmodule

// File: rtl/intsrc_prio_enc.sv
module intsrc_prio_enc
  import intid_pkg::*;
#(
  parameter int              NUM_OBJ   = 32,
  parameter int              ID_W      = 16,
  parameter logic [ID_W-1:0] STATUS_ID = 16'h8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] objPending,
  input  logic               xferDone,
  input  logic               busErr,
  input  logic               busStateChg,
  input  logic               modIntEn,
  input  logic               statusIntEn,
  input  logic               errIntEn,
  input  logic               statusRead,
  output logic [ID_W-1:0]    intId,
  output logic               irq
);

  ctrl_strobe_t strobe;

  intid_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .xferDone    (xferDone),
    .busErr      (busErr),
    .busStateChg (busStateChg),
    .statusIntEn (statusIntEn),
    .errIntEn    (errIntEn),
    .statusRead  (statusRead),
    .strobe      (strobe)
  );

  intid_path #(
    .NUM_OBJ   (NUM_OBJ),
    .ID_W      (ID_W),
    .STATUS_ID (STATUS_ID)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .objPending (objPending),
    .modIntEn   (modIntEn),
    .intId      (intId),
    .irq        (irq)
  );

endmodule

// File: tb/sim_intsrc_prio_enc.sv
`timescale 1ns/1ps
module sim_intsrc_prio_enc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] objPending = '0;
  logic        xferDone = 1'b0, busErr = 1'b0, busStateChg = 1'b0;
  logic        modIntEn = 1'b0, statusIntEn = 1'b0, errIntEn = 1'b0, statusRead = 1'b0;
  logic [15:0] intId;
  logic        irq;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  intsrc_prio_enc u0 (
    .clk(clk), .rst_n(rst_n), .objPending(objPending),
    .xferDone(xferDone), .busErr(busErr), .busStateChg(busStateChg),
    .modIntEn(modIntEn), .statusIntEn(statusIntEn), .errIntEn(errIntEn),
    .statusRead(statusRead), .intId(intId), .irq(irq)
  );

  // {pending[32], xfer, berr, bchg, sEn, eEn, mEn, rd, expId[16], expIrq}
  localparam int NV = 19;
  localparam logic [55:0] VECS [0:NV-1] = '{
    {32'h0000_0000, 7'b000_00_1_0, 16'h0000, 1'b0},  // R2 idle
    {32'h0000_0020, 7'b000_00_1_0, 16'd6,    1'b1},  // R4 object 6
    {32'h0000_0024, 7'b000_00_1_0, 16'd3,    1'b1},  // R5 later lower flag wins
    {32'h0000_0024, 7'b000_00_0_0, 16'd3,    1'b0},  // R6 enable low
    {32'h0000_0024, 7'b100_00_1_0, 16'd3,    1'b1},  // R7 transfer with enable low
    {32'h0000_0024, 7'b001_10_1_0, 16'd3,    1'b1},  // R8 state change, error enable low
    {32'h0000_0024, 7'b100_10_1_0, 16'h8000, 1'b1},  // R7 enabled transfer
    {32'h0000_0024, 7'b000_00_1_0, 16'h8000, 1'b1},  // R9 held
    {32'h0000_0024, 7'b000_00_1_1, 16'd3,    1'b1},  // R9 read clears
    {32'h0000_0000, 7'b010_10_1_0, 16'h8000, 1'b1},  // R7 bus error
    {32'h0000_0000, 7'b001_01_1_1, 16'h8000, 1'b1},  // R10 read with event
    {32'h0000_0000, 7'b000_00_1_1, 16'h0000, 1'b0},  // R9 read clears
    {32'h8000_0000, 7'b000_00_1_0, 16'd32,   1'b1},  // R4 top object
    {32'h8000_0001, 7'b000_00_1_0, 16'd1,    1'b1},  // R4 bottom object
    {32'h0000_0001, 7'b000_00_1_1, 16'd1,    1'b1},  // R11 read ignored
    {32'h0000_0000, 7'b000_00_1_0, 16'h0000, 1'b0},  // R11 flag clear
    {32'hFFFF_FFFF, 7'b001_01_1_0, 16'h8000, 1'b1},  // R3 status above all
    {32'hFFFF_FFFF, 7'b000_00_1_1, 16'd1,    1'b1},  // R3 then lowest object
    {32'h0000_0000, 7'b000_00_1_0, 16'h0000, 1'b0}   // R2 idle again
  };
  localparam string TAGS [0:NV-1] = '{
    "R2", "R4", "R5", "R6", "R7", "R8", "R7", "R9", "R9", "R7",
    "R10", "R9", "R4", "R4", "R11", "R11", "R3", "R3", "R2"
  };

  task automatic chk(input string tag, input logic [15:0] expId, input logic expIrq);
    checkCnt++;
    if (intId !== expId || irq !== expIrq) begin
      failCnt++;
      $display("FAIL %s: intId=%h irq=%b expected intId=%h irq=%b",
               tag, intId, irq, expId, expIrq);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: run hung, expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 chk("R1", 16'h0000, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 chk("R1", 16'h0000, 1'b0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {objPending, xferDone, busErr, busStateChg, statusIntEn, errIntEn,
       modIntEn, statusRead} = VECS[v][55:17];
      @(posedge clk);
      #1 chk(TAGS[v], VECS[v][16:1], VECS[v][0]);
    end

    // R12: a new flag is not visible before the edge, visible right after
    @(negedge clk);
    {xferDone, busErr, busStateChg, statusIntEn, errIntEn, statusRead} = '0;
    modIntEn = 1'b1;
    objPending = 32'h0000_0008;
    #1 chk("R12", 16'h0000, 1'b0);
    @(posedge clk);
    #1 chk("R12", 16'd4, 1'b1);

    // R6: enable acts at once, without an edge
    @(negedge clk) modIntEn = 1'b0;
    #1 chk("R6", 16'd4, 1'b0);

    // R1: reset in the middle of a run drops a pending status
    @(negedge clk);
    modIntEn = 1'b1; statusIntEn = 1'b1; xferDone = 1'b1;
    @(posedge clk);
    #1 chk("R7", 16'h8000, 1'b1);
    @(negedge clk);
    xferDone = 1'b0; statusIntEn = 1'b0; objPending = '0;
    rst_n = 1'b0;
    #1 chk("R1", 16'h0000, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 chk("R1", 16'h0000, 1'b0);

    finishRun();
  end

endmodule